// File: doc/BRIEF.md
# Hierarchical Hit-Pixel Priority Encoder

This block reads out a double column of binary pixel hit flags, one hit per clock. Each pixel keeps a single stored hit bit. A pulse on that pixel's set line raises the bit, and the bit stays up until the pixel is read or the block is reset. A purely combinational tree of identical 4-input cells forms a valid flag and the address of the lowest-numbered pixel that holds a hit. Inside every cell the lowest input index wins.

The periphery is the only clocked logic. On each clock edge where readout is enabled, it captures the tree's valid flag and address into the outputs. In the same edge it sends a select back down the tree along the winning path, and that select clears only the pixel being reported. The next hit therefore appears at the outputs on the following edge. The column holds 1024 pixels, seen as two 512-pixel halves, and the address is 10 bits wide.

Top module: `hit_pe_readout`

## Requirements
- R1: Reset (rst_ni low) clears every stored hit bit and drives valid_o and addr_o to 0. After reset, no hit loaded before the reset is ever reported.
- R2: A one-cycle high pulse on hit_i[i] sets stored bit i. The bit is held across any number of cycles with rd_en_i low and is reported once readout starts.
- R3: On a clock edge with rd_en_i high and at least one stored hit, the outputs after that edge are valid_o=1 and addr_o equal to the lowest index i whose stored bit is set. Pixel i is reported as address i in plain binary: addr_o[9:8] is the root cell input, and addr_o[9] selects the lower (0) or upper (1) 512-pixel half.
- R4: The reported pixel's stored bit is cleared on the same edge. With stable hits, successive enabled edges report every stored pixel exactly once, in ascending order, one per cycle, with no address repeated or skipped.
- R5: After any edge where rd_en_i is low, or where no hit is stored, valid_o=0 and addr_o=0.
- R6: A hit_i pulse on a pixel in the same edge in which that pixel is read is lost, so that pixel is not reported again.
- R7: A hit_i pulse on any other pixel during readout is stored and joins the lowest-first order from the next edge on.
- R8: Extreme addresses are handled: pixel 0, both sides of the half boundary (511 and 512), pixel 1023, and a fully hit column of 1024 pixels read in 1024 consecutive cycles.
- R9: The clear select reaches at most one pixel, and only a pixel that holds a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Periphery clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all hit bits |
| hit_i | input | 1024 | Per-pixel hit set pulses |
| rd_en_i | input | 1 | Readout enable (trigger-started readout) |
| valid_o | output | 1 | A hit address is present on addr_o |
| addr_o | output | 10 | Address of the pixel read on the last edge, 0 when idle |

## Verification
A hit pulse is stored by the edge that samples it. The earliest that pixel can appear on the outputs is the next enabled edge, so a pattern loaded with readout idle shows its first address one edge after rd_en_i rises. After that, each enabled edge reports one address, and the edge after the last one brings valid_o low. The bench drives inputs just after a rising edge and records whether that edge saw the enable. A monitor samples at the falling edge and either pops one expected address per enabled edge or requires the idle value of 0, so a late, early, duplicated or missing address fails in the cycle where it happens. Hits injected during readout (R6, R7) are queued by the driver in the order the requirements give them.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef logic [1:0] loc_t;

  // index of the first node of tree level l (level 0 = pixels)
  function automatic int lvl_off(int l, int npix);
    int o;
    o = 0;
    for (int k = 0; k < l; k++) o += npix >> (2 * k);
    return o;
  endfunction
endpackage

// File: rtl/pe_cell.sv
module pe_cell
  import pe_pkg::*;
(
  input  logic [3:0] v_i,
  input  logic       sel_i,
  output logic       vld_o,
  output loc_t       loc_o,
  output logic [3:0] sel_o
);
  always_comb begin
    if (v_i[0])      loc_o = 2'd0;
    else if (v_i[1]) loc_o = 2'd1;
    else if (v_i[2]) loc_o = 2'd2;
    else             loc_o = 2'd3;
  end

  assign vld_o = |v_i;
  // select travels only to the winning child, and only if it holds a hit
  assign sel_o = sel_i ? ((4'b0001 << loc_o) & v_i) : 4'b0000;
endmodule

// File: rtl/pe_pixel_array.sv
module pe_pixel_array #(
  parameter int N_PIX = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIX-1:0] set_i,
  input  logic [N_PIX-1:0] clr_i,
  output logic [N_PIX-1:0] hit_q
);
  // clear wins over a set arriving in the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= '0;
    else         hit_q <= (hit_q | set_i) & ~clr_i;
  end
endmodule

// File: rtl/pe_tree.sv
module pe_tree
  import pe_pkg::*;
#(
  parameter int LEVELS = 5,
  localparam int N_PIX = 4 ** LEVELS,
  localparam int AW    = 2 * LEVELS
) (
  input  logic [N_PIX-1:0] hit_i,
  input  logic             grant_i,
  output logic             vld_o,
  output logic [AW-1:0]    adr_o,
  output logic [N_PIX-1:0] sel_o
);
  localparam int TOT  = lvl_off(LEVELS + 1, N_PIX);
  localparam int ROOT = TOT - 1;

  wire [TOT-1:0] nv;
  wire [TOT-1:0] nsel;
  wire [AW-1:0]  nadr [TOT];

  assign nv[N_PIX-1:0] = hit_i;
  assign nsel[ROOT]    = grant_i;
  assign sel_o         = nsel[N_PIX-1:0];
  assign vld_o         = nv[ROOT];
  assign adr_o         = nadr[ROOT];

  for (genvar i = 0; i < N_PIX; i++) begin : g_leaf
    assign nadr[i] = '0;
  end

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int NC = N_PIX >> (2 * l);
    for (genvar c = 0; c < NC; c++) begin : g_cell
      localparam int OC = lvl_off(l, N_PIX) + c;
      localparam int OB = lvl_off(l - 1, N_PIX) + 4 * c;
      loc_t loc;
      pe_cell u_cell (
        .v_i   (nv[OB+:4]),
        .sel_i (nsel[OC]),
        .vld_o (nv[OC]),
        .loc_o (loc),
        .sel_o (nsel[OB+:4])
      );
      // cells nearer the root contribute higher address bits
      assign nadr[OC] = nadr[OB + int'(loc)] | (AW'(loc) << (2 * (l - 1)));
    end
  end
endmodule

// File: rtl/hit_pe_readout.sv
module hit_pe_readout #(
  parameter int LEVELS = 5,
  localparam int N_PIX = 4 ** LEVELS,
  localparam int AW    = 2 * LEVELS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIX-1:0] hit_i,
  input  logic             rd_en_i,
  output logic             valid_o,
  output logic [AW-1:0]    addr_o
);
  logic [N_PIX-1:0] hit_q;
  logic [N_PIX-1:0] pix_sel;
  logic             tree_vld;
  logic [AW-1:0]    tree_adr;
  logic             grant;

  assign grant = rd_en_i & tree_vld;

  pe_pixel_array #(.N_PIX(N_PIX)) u_pix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit_i),
    .clr_i  (pix_sel),
    .hit_q  (hit_q)
  );

  pe_tree #(.LEVELS(LEVELS)) u_tree (
    .hit_i   (hit_q),
    .grant_i (grant),
    .vld_o   (tree_vld),
    .adr_o   (tree_adr),
    .sel_o   (pix_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= grant;
      addr_o  <= grant ? tree_adr : '0;
    end
  end
endmodule

// File: rtl/hit_pe_readout_chk.sv
module hit_pe_readout_chk #(
  parameter int LEVELS = 5,
  localparam int N_PIX = 4 ** LEVELS,
  localparam int AW    = 2 * LEVELS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic             valid_o,
  input logic [AW-1:0]    addr_o,
  input logic [N_PIX-1:0] hit_q,
  input logic [N_PIX-1:0] pix_sel
);
  logic [N_PIX-1:0] hit_d;
  logic [N_PIX-1:0] low_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_d <= '0;
    else         hit_d <= hit_q;
  end

  assign low_mask = (N_PIX'(1) << addr_o) - N_PIX'(1);

  // R3
  lowest_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (hit_d[addr_o] && ((hit_d & low_mask) == '0)));
  // R3
  next_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (|hit_q)) |=> valid_o);
  // R4
  cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !hit_q[addr_o]);
  // R4
  no_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> (addr_o != $past(addr_o)));
  // R5
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (addr_o == '0));
  // R5
  rd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !valid_o);
  // R9
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pix_sel));
  // R9
  sel_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_sel & ~hit_q) == '0);
endmodule

bind hit_pe_readout hit_pe_readout_chk #(.LEVELS(LEVELS)) i_chk (.*);

// File: tb/test_hit_pe_readout.sv
module test_hit_pe_readout;
  localparam int CLK_PERIOD = 10;
  localparam int LV = 5;
  localparam int NP = 4 ** LV;
  localparam int AW = 2 * LV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] hit_i = '0;
  logic          rd_en = 1'b0;
  logic          valid_o;
  logic [AW-1:0] addr_o;

  int n_chk = 0;
  int n_fail = 0;
  logic sb_on = 1'b0;
  logic rd_seen = 1'b0;
  logic [AW-1:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  hit_pe_readout #(.LEVELS(LV)) i_hit_pe_readout (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .hit_i   (hit_i),
    .rd_en_i (rd_en),
    .valid_o (valid_o),
    .addr_o  (addr_o)
  );

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // did the last rising edge see the enable
  always @(posedge clk) rd_seen <= rd_en;

  // monitor: one expected address per enabled edge, else idle zero
  always @(negedge clk) begin
    if (sb_on) begin
      if (rd_seen && exp_q.size() > 0) begin
        automatic logic [AW-1:0] e = exp_q.pop_front();
        chk("R3/R4 addr", valid_o && addr_o == e, valid_o ? int'(addr_o) : -1, int'(e));
      end else begin
        chk("R5 idle", !valid_o && addr_o == '0, int'({valid_o, addr_o}), 0);
      end
    end
  end

  task automatic push_pat(input logic [NP-1:0] p);
    for (int i = 0; i < NP; i++) if (p[i]) exp_q.push_back(AW'(i));
  endtask

  // driver: pulses hits, ends just after the storing edge
  task automatic load(input logic [NP-1:0] p);
    @(posedge clk); #1;
    hit_i = p;
    push_pat(p);
    @(posedge clk); #1;
    hit_i = '0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic rand_burst(input int nhit);
    logic [NP-1:0] p;
    p = '0;
    for (int k = 0; k < nhit; k++) p[$urandom_range(NP - 1, 0)] = 1'b1;
    load(p);
    rd_en = 1'b1;
    drain();
  endtask

  initial begin
    // R1: reset state
    #(CLK_PERIOD / 4);
    chk("R1 reset outputs", !valid_o && addr_o == '0, int'({valid_o, addr_o}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: hits loaded before a reset are dropped
    hit_i = NP'(1) << 77 | NP'(1) << 600;
    @(posedge clk); #1;
    hit_i = '0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 outputs in reset", !valid_o && addr_o == '0, int'({valid_o, addr_o}), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 no stale hit", !valid_o, int'(valid_o), 0);
    end
    @(posedge clk); #1;
    rd_en = 1'b0;
    @(posedge clk); #1;

    sb_on = 1'b1;
    // R2: hits held while readout idle, then reported
    load(NP'(1) << 300 | NP'(1) << 40 | NP'(1) << 900);
    repeat (5) @(posedge clk);
    #1;
    rd_en = 1'b1;
    drain();

    // R3 R4: random patterns
    for (int b = 0; b < 8; b++) rand_burst(4 + 6 * b);

    // R8: extremes and the half boundary
    load(NP'(1) | NP'(1) << 511 | NP'(1) << 512 | NP'(1) << (NP - 1));
    rd_en = 1'b1;
    drain();
    // R8: full column
    load('1);
    rd_en = 1'b1;
    drain();

    // R6: re-hit of the pixel being read is lost
    load(NP'(1) << 5 | NP'(1) << 9);
    rd_en = 1'b1;
    hit_i = NP'(1) << 5;
    @(posedge clk); #1;
    hit_i = '0;
    drain();

    // R7: new hits during readout join the order
    load(NP'(1) << 20);
    rd_en = 1'b1;
    hit_i = NP'(1) << 3 | NP'(1) << 30;
    exp_q.push_back(AW'(3));
    exp_q.push_back(AW'(30));
    @(posedge clk); #1;
    hit_i = '0;
    drain();

    // R5 R2: pause in the middle of a readout
    load(NP'(1) << 1 | NP'(1) << 2 | NP'(1) << 3);
    rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rd_en = 1'b1;
    drain();

    sb_on = 1'b0;
    chk("R4 queue empty", exp_q.size() == 0, exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R4 act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule